// File: doc/BRIEF.md
# Fault Shutoff Latch with Selectable Release Policy

This block guards one output channel of a PWM power stage. It watches a fault input picked from a small set of sources, with a programmable active level. When that fault becomes active, the block latches a shutoff state and replaces the channel's main and complementary outputs with two safe levels that are programmed separately. The functional outputs normally come from a dead-time stage upstream. While the latch is set, they are ignored.

The latch is released according to a programmed policy. The first policy releases only on a software clear strobe. The second releases on one chosen edge: the rising or falling edge of this channel's PWM input, or the rising or falling edge of the neighbouring channel's PWM input. The third releases as soon as the synchronised fault goes inactive. The clear strobe releases the latch in every armed policy.

If the fault is still active when any release occurs, the latch stays set. A global enable turns the shutoff function on. Configuration fields change only when their write carries the channel's write-enable bit. A status output shows whether the channel is currently shut off.

Top module: `fault_shutoff_latch`

## Requirements
- R1: After reset, out_main equals func_main, out_comp equals func_comp, and shut_status is 0.
- R2: cfg_src_sel picks fault_src[cfg_src_sel]. Indices 0 and 1 are the timer inputs and 2 to 5 are the auxiliary inputs. Sources that are not selected have no effect. An index of NUM_SRC or above never raises a fault.
- R3: When cfg_act_low is 0, the selected source is active when high. When cfg_act_low is 1, it is active when low.
- R4: A fault change on the input reaches shut_status at the third rising clock edge after the change (two synchroniser stages, then the latch). While shut off, out_main equals the stored safe main level and out_comp equals the stored safe complementary level.
- R5: With cfg_rel_mode = 1, only clr_strobe releases the latch. Fault deassertion and PWM edges do not.
- R6: With cfg_rel_mode = 2, the latch releases on the clock edge that samples the selected PWM edge. The cfg_edge_sel encodings are: 0 = pwm_cur falling, 1 = pwm_cur rising, 2 = pwm_prev falling, 3 = pwm_prev rising. Edges on the line that is not selected, or in the other direction, do not release.
- R7: With cfg_rel_mode = 3, the latch releases at the third rising edge after the fault input goes inactive.
- R8: clr_strobe releases the latch in modes 1, 2 and 3. Any release is overridden while the synchronised fault is still active, so the latch stays set.
- R9: A write (cfg_wr = 1) updates the stored configuration only if cfg_wr_en = 1 in the same cycle. Otherwise the stored configuration, including the safe levels, keeps its value.
- R10: When glb_en = 0 or the stored mode is 0, the latch clears on the next edge and never sets, and the outputs pass the functional signals through.
- R11: shut_status is 1 exactly while the outputs are forced to their safe levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_src | input | NUM_SRC | Candidate fault inputs |
| pwm_cur | input | 1 | This channel's PWM input |
| pwm_prev | input | 1 | Neighbouring channel's PWM input |
| func_main | input | 1 | Main output from the dead-time stage |
| func_comp | input | 1 | Complementary output from the dead-time stage |
| glb_en | input | 1 | Global shutoff enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_en | input | 1 | Channel write-enable bit for this write |
| cfg_src_sel | input | SEL_W | Fault source index |
| cfg_act_low | input | 1 | 1 = fault active low |
| cfg_rel_mode | input | 2 | Release policy: 0 off, 1 strobe, 2 edge, 3 fault gone |
| cfg_edge_sel | input | 2 | Release edge selection for mode 2 |
| cfg_safe_main | input | 1 | Safe level for the main output |
| cfg_safe_comp | input | 1 | Safe level for the complementary output |
| clr_strobe | input | 1 | Software clear of the latch |
| out_main | output | 1 | Gated main output |
| out_comp | output | 1 | Gated complementary output |
| shut_status | output | 1 | 1 while the channel is shut off |

## Verification
The bench checks the exact latency of the synchroniser by sampling one edge before and one edge at the expected entry into shutoff. A design with one stage too many or too few fails that check.

Each of the four release edges is driven, preceded by a decoy edge on the other PWM line. A design with swapped encodings, or one that reacts to the wrong line, would release early or never.

The bench also attempts a release while the fault is still active. A design that gives release priority over set would drop the protection during a live fault.

Finally, a write without the enable bit tries to change the safe levels and the mode while the channel is shut off. A design that ignores the enable bit would visibly change the forced outputs.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

   typedef enum logic [1:0] {
      REL_OFF        = 2'd0,
      REL_STROBE     = 2'd1,
      REL_EDGE       = 2'd2,
      REL_FAULT_GONE = 2'd3
   } rel_mode_e;

   typedef enum logic [1:0] {
      EDG_CUR_FALL  = 2'd0,
      EDG_CUR_RISE  = 2'd1,
      EDG_PREV_FALL = 2'd2,
      EDG_PREV_RISE = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic      act_low;
      rel_mode_e mode;
      edge_sel_e edge_sel;
      logic      safe_main;
      logic      safe_comp;
   } shut_cfg_t;

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("fsl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fsl_cfg_regs.sv
module fsl_cfg_regs
   import fsl_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] src_sel_in,
   input  shut_cfg_t        cfg_in,
   output logic [SEL_W-1:0] src_sel_q,
   output shut_cfg_t        cfg_q
);
   logic commit;
   assign commit = wr & wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_sel_q <= '0;
         cfg_q     <= '{act_low: 1'b0, mode: REL_OFF, edge_sel: EDG_CUR_FALL,
                        safe_main: 1'b0, safe_comp: 1'b0};
      end else if (commit) begin
         src_sel_q <= src_sel_in;
         cfg_q     <= cfg_in;
      end
   end

   // R9: without the enable bit the stored fields hold
   a_r9_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wr_en) |=> ($stable(cfg_q) && $stable(src_sel_q)));
endmodule

// File: rtl/fsl_release_sel.sv
module fsl_release_sel
   import fsl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rel_mode_e mode,
   input  edge_sel_e edge_sel,
   input  logic      pwm_cur,
   input  logic      pwm_prev,
   input  logic      clr,
   input  logic      fault_act,
   output logic      release_now
);
   logic cur_q, prev_q;
   logic edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         cur_q  <= pwm_cur;
         prev_q <= pwm_prev;
      end
   end

   always_comb begin
      unique case (edge_sel)
         EDG_CUR_FALL:  edge_hit = cur_q & ~pwm_cur;
         EDG_CUR_RISE:  edge_hit = ~cur_q & pwm_cur;
         EDG_PREV_FALL: edge_hit = prev_q & ~pwm_prev;
         default:       edge_hit = ~prev_q & pwm_prev;
      endcase
   end

   always_comb begin
      unique case (mode)
         REL_STROBE:     release_now = clr;
         REL_EDGE:       release_now = clr | edge_hit;
         REL_FAULT_GONE: release_now = clr | ~fault_act;
         default:        release_now = 1'b0;
      endcase
   end

   // R6: a sampled rising edge of the current input must release in that mode
   a_r6_cur_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == REL_EDGE && edge_sel == EDG_CUR_RISE && $rose(pwm_cur)) |-> release_now);
endmodule

// File: rtl/fsl_latch_core.sv
module fsl_latch_core (
   input  logic clk,
   input  logic rst_n,
   input  logic glb_en,
   input  logic armed,
   input  logic fault_act,
   input  logic release_now,
   output logic shut
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shut <= 1'b0;
      else if (!glb_en || !armed) shut <= 1'b0;
      else if (fault_act)         shut <= 1'b1;
      else if (release_now)       shut <= 1'b0;
   end

   // R10: disabled or unarmed channel never holds the latch
   a_r10_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en || !armed) |=> !shut);
   // R4 / R8: an active fault sets the latch, whatever release says
   a_r8_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && armed && fault_act) |=> shut);
   // R5: without a release the latch holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (shut && glb_en && armed && !release_now) |=> shut);
endmodule

// File: rtl/fault_shutoff_latch.sv
module fault_shutoff_latch
   import fsl_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] fault_src,
   input  logic               pwm_cur,
   input  logic               pwm_prev,
   input  logic               func_main,
   input  logic               func_comp,
   input  logic               glb_en,
   input  logic               cfg_wr,
   input  logic               cfg_wr_en,
   input  logic [SEL_W-1:0]   cfg_src_sel,
   input  logic               cfg_act_low,
   input  logic [1:0]         cfg_rel_mode,
   input  logic [1:0]         cfg_edge_sel,
   input  logic               cfg_safe_main,
   input  logic               cfg_safe_comp,
   input  logic               clr_strobe,
   output logic               out_main,
   output logic               out_comp,
   output logic               shut_status
);
   if ((1 << SEL_W) < NUM_SRC) begin : g_bad_sel
      $error("fault_shutoff_latch: SEL_W too narrow for NUM_SRC");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("fault_shutoff_latch: NUM_SRC must be positive");
   end

   shut_cfg_t        cfg_in, cfg_q;
   logic [SEL_W-1:0] src_q;
   logic             src_ok, raw_sel, sync_q, fault_act;
   logic             release_now, shut, armed;

   assign cfg_in = '{act_low:   cfg_act_low,
                     mode:      rel_mode_e'(cfg_rel_mode),
                     edge_sel:  edge_sel_e'(cfg_edge_sel),
                     safe_main: cfg_safe_main,
                     safe_comp: cfg_safe_comp};

   fsl_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cfg_wr),
      .wr_en      (cfg_wr_en),
      .src_sel_in (cfg_src_sel),
      .cfg_in     (cfg_in),
      .src_sel_q  (src_q),
      .cfg_q      (cfg_q)
   );

   always_comb begin
      raw_sel = 1'b0;
      src_ok  = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (src_q == SEL_W'(i)) begin
            raw_sel = fault_src[i];
            src_ok  = 1'b1;
         end
      end
   end

   fsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_sel),
      .q     (sync_q)
   );

   assign fault_act = src_ok & (sync_q ^ cfg_q.act_low);
   assign armed     = (cfg_q.mode != REL_OFF);

   fsl_release_sel u_rel (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (cfg_q.mode),
      .edge_sel    (cfg_q.edge_sel),
      .pwm_cur     (pwm_cur),
      .pwm_prev    (pwm_prev),
      .clr         (clr_strobe),
      .fault_act   (fault_act),
      .release_now (release_now)
   );

   fsl_latch_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .glb_en      (glb_en),
      .armed       (armed),
      .fault_act   (fault_act),
      .release_now (release_now),
      .shut        (shut)
   );

   assign out_main    = shut ? cfg_q.safe_main : func_main;
   assign out_comp    = shut ? cfg_q.safe_comp : func_comp;
   assign shut_status = shut;

   // R2: a source index outside the set never produces an active fault
   a_r2_bad_index_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q >= SEL_W'(NUM_SRC)) |-> !fault_act);
endmodule

// File: tb/fault_shutoff_latch_test.sv
module fault_shutoff_latch_test;
   localparam int NSRC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0] fault_src = '0;
   logic pwm_cur = 1'b0, pwm_prev = 1'b0;
   logic func_main = 1'b1, func_comp = 1'b0;
   logic glb_en = 1'b0;
   logic cfg_wr = 1'b0, cfg_wr_en = 1'b0;
   logic [2:0] cfg_src_sel = '0;
   logic cfg_act_low = 1'b0;
   logic [1:0] cfg_rel_mode = '0, cfg_edge_sel = '0;
   logic cfg_safe_main = 1'b0, cfg_safe_comp = 1'b0;
   logic clr_strobe = 1'b0;
   logic out_main, out_comp, shut_status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fault_shutoff_latch uut (
      .clk(clk), .rst_n(rst_n), .fault_src(fault_src),
      .pwm_cur(pwm_cur), .pwm_prev(pwm_prev),
      .func_main(func_main), .func_comp(func_comp), .glb_en(glb_en),
      .cfg_wr(cfg_wr), .cfg_wr_en(cfg_wr_en), .cfg_src_sel(cfg_src_sel),
      .cfg_act_low(cfg_act_low), .cfg_rel_mode(cfg_rel_mode),
      .cfg_edge_sel(cfg_edge_sel), .cfg_safe_main(cfg_safe_main),
      .cfg_safe_comp(cfg_safe_comp), .clr_strobe(clr_strobe),
      .out_main(out_main), .out_comp(out_comp), .shut_status(shut_status)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input bit exp_shut, input bit em, input bit ec);
      chk(shut_status == exp_shut, {req, " status"}, shut_status, exp_shut);
      chk(out_main == em, {req, " out_main"}, out_main, em);
      chk(out_comp == ec, {req, " out_comp"}, out_comp, ec);
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic cfg_write(input bit en, input int src, input bit low, input int mode,
                            input int edg, input bit sm, input bit sc);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wr_en = en; cfg_src_sel = 3'(src); cfg_act_low = low;
      cfg_rel_mode = 2'(mode); cfg_edge_sel = 2'(edg);
      cfg_safe_main = sm; cfg_safe_comp = sc;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wr_en = 1'b0;
   endtask

   task automatic set_fault(input int idx, input bit v);
      @(negedge clk);
      fault_src[idx] = v;
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr_strobe = 1'b1;
      edges(1);
      @(negedge clk);
      clr_strobe = 1'b0;
   endtask

   task automatic t_reset();
      #2;
      chk_state("R1 reset", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_unarmed();
      cfg_write(1, 0, 0, 0, 0, 0, 1);
      set_fault(0, 1'b1);
      edges(5);
      chk_state("R10 mode0", 1'b0, 1'b1, 1'b0);
      set_fault(0, 1'b0);
      edges(3);
   endtask

   task automatic t_latency_strobe();
      cfg_write(1, 2, 0, 1, 0, 0, 1);
      set_fault(2, 1'b1);
      edges(2);
      chk_state("R4 before entry", 1'b0, 1'b1, 1'b0);
      edges(1);
      chk_state("R4 entry safe levels", 1'b1, 1'b0, 1'b1);
      set_fault(2, 1'b0);
      edges(5);
      chk(shut_status == 1'b1, "R5 fault gone holds", shut_status, 1);
      @(negedge clk); pwm_cur = 1'b1;
      edges(2);
      @(negedge clk); pwm_cur = 1'b0;
      edges(2);
      chk(shut_status == 1'b1, "R5 pwm edges ignored", shut_status, 1);
      pulse_clear();
      chk_state("R5 strobe releases", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_source_select();
      cfg_write(1, 1, 0, 1, 0, 1, 1);
      set_fault(0, 1'b1);
      set_fault(3, 1'b1);
      edges(5);
      chk(shut_status == 1'b0, "R2 unselected ignored", shut_status, 0);
      set_fault(0, 1'b0);
      set_fault(3, 1'b0);
      cfg_write(1, 6, 0, 1, 0, 1, 1);
      @(negedge clk); fault_src = '1;
      edges(5);
      chk(shut_status == 1'b0, "R2 index out of range", shut_status, 0);
      @(negedge clk); fault_src = '0;
      edges(3);
      cfg_write(1, 1, 0, 1, 0, 1, 1);
      set_fault(1, 1'b1);
      edges(3);
      chk(shut_status == 1'b1, "R2 timer input 1 selected", shut_status, 1);
      set_fault(1, 1'b0);
      edges(3);
      pulse_clear();
   endtask

   task automatic t_polarity();
      cfg_write(1, 4, 1, 1, 0, 0, 1);
      edges(3);
      chk(shut_status == 1'b1, "R3 active low idle input", shut_status, 1);
      set_fault(4, 1'b1);
      edges(3);
      pulse_clear();
      chk(shut_status == 1'b0, "R3 high is inactive", shut_status, 0);
      edges(4);
      chk(shut_status == 1'b0, "R3 stays clear", shut_status, 0);
      set_fault(4, 1'b0);
      edges(3);
      chk(shut_status == 1'b1, "R3 low retriggers", shut_status, 1);
      set_fault(4, 1'b1);
      edges(3);
      pulse_clear();
   endtask

   task automatic t_edges();
      for (int e = 0; e < 4; e++) begin
         bit idle;
         bit on_prev;
         idle    = (e == 0 || e == 2);
         on_prev = (e >= 2);
         cfg_write(1, 0, 0, 2, e, 0, 1);
         @(negedge clk); pwm_cur = idle; pwm_prev = idle;
         edges(2);
         set_fault(0, 1'b1);
         edges(3);
         chk(shut_status == 1'b1, "R6 entry", shut_status, 1);
         set_fault(0, 1'b0);
         edges(3);
         @(negedge clk);
         if (on_prev) pwm_cur = ~idle; else pwm_prev = ~idle;
         edges(2);
         chk(shut_status == 1'b1, "R6 decoy line ignored", shut_status, 1);
         @(negedge clk);
         if (on_prev) pwm_prev = ~idle; else pwm_cur = ~idle;
         edges(1);
         chk_state("R6 selected edge releases", 1'b0, 1'b1, 1'b0);
         @(negedge clk); pwm_cur = 1'b0; pwm_prev = 1'b0;
         edges(2);
      end
   endtask

   task automatic t_fault_priority();
      cfg_write(1, 0, 0, 2, 1, 0, 1);
      set_fault(0, 1'b1);
      edges(3);
      @(negedge clk); pwm_cur = 1'b1;
      edges(1);
      chk(shut_status == 1'b1, "R8 edge during live fault", shut_status, 1);
      @(negedge clk); pwm_cur = 1'b0;
      pulse_clear();
      chk(shut_status == 1'b1, "R8 strobe during live fault", shut_status, 1);
      set_fault(0, 1'b0);
      edges(3);
      pulse_clear();
      chk(shut_status == 1'b0, "R8 strobe after fault", shut_status, 0);
   endtask

   task automatic t_fault_gone();
      cfg_write(1, 5, 0, 3, 0, 1, 1);
      set_fault(5, 1'b1);
      edges(3);
      chk_state("R7 entry both high", 1'b1, 1'b1, 1'b1);
      set_fault(5, 1'b0);
      edges(2);
      chk(shut_status == 1'b1, "R7 before release", shut_status, 1);
      edges(1);
      chk_state("R7 release", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_write_enable();
      cfg_write(1, 0, 0, 1, 0, 0, 1);
      set_fault(0, 1'b1);
      edges(3);
      set_fault(0, 1'b0);
      edges(3);
      cfg_write(0, 0, 0, 0, 0, 1, 0);
      edges(2);
      chk_state("R9 write without enable", 1'b1, 1'b0, 1'b1);
      pulse_clear();
      chk(shut_status == 1'b0, "R9 cleanup", shut_status, 0);
   endtask

   task automatic t_global();
      cfg_write(1, 0, 0, 1, 0, 0, 1);
      set_fault(0, 1'b1);
      edges(3);
      chk(shut_status == 1'b1, "R10 armed entry", shut_status, 1);
      @(negedge clk); glb_en = 1'b0;
      edges(1);
      chk_state("R10 global off releases", 1'b0, 1'b1, 1'b0);
      edges(4);
      chk(shut_status == 1'b0, "R10 stays off with live fault", shut_status, 0);
      set_fault(0, 1'b0);
      edges(3);
      @(negedge clk); glb_en = 1'b1;
      edges(3);
      chk(shut_status == 1'b0, "R11 quiet after enable", shut_status, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      edges(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1; glb_en = 1'b1;
      edges(2);
      t_reset();
      t_unarmed();
      t_latency_strobe();
      t_source_select();
      t_polarity();
      t_edges();
      t_fault_priority();
      t_fault_gone();
      t_write_enable();
      t_global();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule